// File: doc/BRIEF.md
# Configurable SPI Word Master

This block is the controller end of a serial peripheral link. It moves one word per request. A single-cycle `start` strobe loads the transmit word and the mode settings. The block then lowers the select line and clocks the word out on a generated serial clock. At the same time it assembles the word coming back from the peripheral. When the select line is released, `done` pulses for one cycle and `rx_word` holds the received value.

Four settings are chosen at run time and latched when a transfer is accepted: the clock idle level (`cpol`), the clock phase (`cpha`), a word length from 3 to 16 bits, and the bit order. The link runs either with separate out and in lines at the same time, or over a single shared data pin. On the shared pin, a direction input decides whether the block drives the pin or releases it and listens. Each half of a serial clock period lasts a programmable number of system clocks.

The controller has five states:
- IDLE: select high, clock at the live `cpol` level.
- SETUP: select low and the first bit on the line, for one half-period.
- FIRST_HALF and SECOND_HALF: the two halves of each bit slot.
- HOLD: one quiet half-period before the select rises.

Its transitions are:
- IDLE→SETUP when `start` arrives.
- SETUP→FIRST_HALF at the end of the half-period.
- FIRST_HALF→SECOND_HALF at the end of the half-period, which is also where input is sampled.
- SECOND_HALF→FIRST_HALF while bits remain.
- SECOND_HALF→HOLD after the last bit.
- HOLD→IDLE, which raises `done`.

Top module: `spi_word_master`

## Requirements
- R1: While idle, `ss_n` is 1, `sclk` equals the `cpol` input, `sio_oe` is 0 and `done` is 0; after reset `rx_word` is 0.
- R2: A transfer uses L bits, where L is `word_len` clamped into 3..16 (values below 3 give 3, values above 16 give 16). It produces exactly 2·L `sclk` transitions while `ss_n` is low.
- R3: With `cpha`=0 the first bit is on the line before the first `sclk` edge, and input is sampled on the leading edge of each pulse. With `cpha`=1 the leading edge launches and the trailing edge samples. Sampling happens on rising `sclk` when `cpol`=`cpha`, and on falling `sclk` otherwise.
- R4: With `lsb_first`=1, bit 0 of the word goes first; with `lsb_first`=0, bit L-1 goes first. Received bits are placed with the same rule, and `rx_word` bits at L and above read 0.
- R5: With `three_wire`=0, `mosi` carries the transmit word, `rx_word` is built from `miso`, and `sio_oe` stays 0.
- R6: With `three_wire`=1 and `dir_tx`=0, `sio_oe` stays 0, `mosi` stays 0, and `rx_word` is built from `sio_in`.
- R7: With `three_wire`=1 and `dir_tx`=1, `sio_oe` is 1 in exactly the cycles where `ss_n` is 0, `mosi` carries the word, and `rx_word` ends as 0.
- R8: Every state lasts D = max(`half_div`,1) system clocks, so `ss_n` is low for D·(2L+2) cycles. At least D cycles separate the fall of `ss_n` from the first `sclk` edge, and the last edge from the rise of `ss_n`.
- R9: `done` is a one-cycle pulse in the first cycle that `ss_n` is high again. `rx_word` is valid then and holds until the next accepted `start`.
- R10: A `start`, or a change to any mode, length, divider or transmit input, while `ss_n` is low has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| tx_word | input | DW | Word to send |
| word_len | input | LENW | Requested bit count, clamped to 3..DW |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsb_first | input | 1 | 1: bit 0 goes first |
| three_wire | input | 1 | 1: single shared data pin |
| dir_tx | input | 1 | Shared-pin direction: 1 drive, 0 listen |
| half_div | input | DIVW | System clocks per half-period (0 acts as 1) |
| miso | input | 1 | Serial input in separate-line mode |
| sio_in | input | 1 | Input side of the shared data pin |
| rx_word | output | DW | Received word |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while a transfer is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output, also the drive value for the shared pin |
| ss_n | output | 1 | Active-low select |
| sio_oe | output | 1 | Output enable for the shared pin |

## Verification
A wrong state or bit counter shows at the ports within one transfer. The number of `sclk` transitions moves away from 2·L, or the `ss_n` low time moves away from D·(2L+2). A wrong phase or sample point shows as the wrong level of `sclk` at a sampling edge, or as a corrupted word at the bench's model peripheral. Both words are compared when `done` pulses. A wrong line selection or output enable shows as a wrong `rx_word` or as `sio_oe` cycles that do not match the select window. So the bench checks every transfer across random modes, lengths and dividers, and also runs directed cases for clamped lengths, a zero divider and requests made while busy.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_FIRST,
        ST_SECOND,
        ST_HOLD
    } spim_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic three_wire;
        logic dir_tx;
    } spim_mode_t;

endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] half_div,
    output logic            tick
);
    logic [DIVW-1:0] cnt_q;
    logic [DIVW-1:0] lim;

    assign lim  = (half_div == '0) ? {{(DIVW-1){1'b0}}, 1'b1} : half_div;
    assign tick = run && (cnt_q == lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run)       cnt_q <= '0;
        else if (tick)       cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    // R8
    half_period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

    // R8
    idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/spim_datapath.sv
module spim_datapath #(
    parameter int DW   = 16,
    parameter int LENW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DW-1:0]   tx_word,
    input  logic [LENW-1:0] len,
    input  logic            lsb_first,
    input  logic [LENW-1:0] bitcnt,
    input  logic            sample_en,
    input  logic            din,
    output logic            tx_bit,
    output logic [DW-1:0]   rx_word
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0]   tx_q;
    logic [DW-1:0]   rx_q;
    logic [LENW-1:0] pos_full;
    logic [IW-1:0]   pos;

    always_comb begin
        if (lsb_first) pos_full = bitcnt;
        else           pos_full = len - 1'b1 - bitcnt;
        pos = pos_full[IW-1:0];
    end

    assign tx_bit  = tx_q[pos];
    assign rx_word = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= tx_word;
            rx_q <= '0;
        end else if (sample_en) begin
            rx_q[pos] <= din;
        end
    end

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !sample_en) |=> $stable(rx_q));

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(tx_q));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spim_pkg::*;
#(
    parameter int DW   = 16,
    parameter int DIVW = 8,
    parameter int LENW = $clog2(DW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DW-1:0]   tx_word,
    input  logic [LENW-1:0] word_len,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            lsb_first,
    input  logic            three_wire,
    input  logic            dir_tx,
    input  logic [DIVW-1:0] half_div,
    input  logic            miso,
    input  logic            sio_in,
    output logic [DW-1:0]   rx_word,
    output logic            done,
    output logic            busy,
    output logic            sclk,
    output logic            mosi,
    output logic            ss_n,
    output logic            sio_oe
);
    localparam logic [LENW-1:0] MIN_LEN = LENW'(3);
    localparam logic [LENW-1:0] MAX_LEN = LENW'(DW);

    spim_state_e     state_q, state_d;
    spim_mode_t      mode_q;
    logic [LENW-1:0] len_q;
    logic [DIVW-1:0] div_q;
    logic [LENW-1:0] bit_q;
    logic            done_q;
    logic            tick;
    logic            accept;
    logic            last_bit;
    logic            sample_en;
    logic            tx_bit;
    logic            din;
    logic            listening;
    logic [LENW-1:0] len_eff;

    assign accept    = (state_q == ST_IDLE) && start;
    assign last_bit  = (bit_q == len_q - 1'b1);
    assign listening = !(mode_q.three_wire && mode_q.dir_tx);
    assign sample_en = (state_q == ST_FIRST) && tick && listening;
    assign din       = mode_q.three_wire ? sio_in : miso;

    always_comb begin
        if (word_len < MIN_LEN)      len_eff = MIN_LEN;
        else if (word_len > MAX_LEN) len_eff = MAX_LEN;
        else                         len_eff = word_len;
    end

    spim_divider #(.DIVW(DIVW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .half_div (div_q),
        .tick     (tick)
    );

    spim_datapath #(.DW(DW), .LENW(LENW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .tx_word   (tx_word),
        .len       (len_q),
        .lsb_first (mode_q.lsb_first),
        .bitcnt    (bit_q),
        .sample_en (sample_en),
        .din       (din),
        .tx_bit    (tx_bit),
        .rx_word   (rx_word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  if (tick)  state_d = ST_FIRST;
            ST_FIRST:  if (tick)  state_d = ST_SECOND;
            ST_SECOND: if (tick)  state_d = last_bit ? ST_HOLD : ST_FIRST;
            ST_HOLD:   if (tick)  state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // state register and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            len_q   <= MIN_LEN;
            div_q   <= '0;
            bit_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_HOLD) && tick;
            if (accept) begin
                mode_q <= '{cpol: cpol, cpha: cpha, lsb_first: lsb_first,
                            three_wire: three_wire, dir_tx: dir_tx};
                len_q  <= len_eff;
                div_q  <= half_div;
                bit_q  <= '0;
            end else if ((state_q == ST_SECOND) && tick && !last_bit) begin
                bit_q  <= bit_q + 1'b1;
            end
        end
    end

    // Moore outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        ss_n   = !busy;
        done   = done_q;
        sio_oe = busy && mode_q.three_wire && mode_q.dir_tx;
        mosi   = (busy && listening && mode_q.three_wire) ? 1'b0 : (busy && tx_bit);
        unique case (state_q)
            ST_IDLE:   sclk = cpol;
            ST_FIRST:  sclk = mode_q.cpol ^ mode_q.cpha;
            ST_SECOND: sclk = mode_q.cpol ^ !mode_q.cpha;
            default:   sclk = mode_q.cpol;
        endcase
    end

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> (sclk == cpol) && !sio_oe);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ss_n && $past(!ss_n));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q) && $stable(len_q) && $stable(div_q));

    // R2
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_q < len_q));

    // R8
    quiet_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SETUP || state_q == ST_HOLD) && $past(state_q) == state_q)
        |-> $stable(sclk));

    // R7
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe |-> !ss_n);

endmodule

// File: tb/tb_spi_word_master.sv
`timescale 1ns/1ps
module tb_spi_word_master;
    localparam int DW = 16, DIVW = 8, LENW = 5;

    logic clk = 0, rst_n = 0, start = 0;
    logic [DW-1:0] tx_word = '0;
    logic [LENW-1:0] word_len = 5'd8;
    logic cpol = 0, cpha = 0, lsb_first = 0, three_wire = 0, dir_tx = 0;
    logic [DIVW-1:0] half_div = 8'd1;
    logic miso, sio_in;
    logic [DW-1:0] rx_word;
    logic done, busy, sclk, mosi, ss_n, sio_oe;

    always #2.5 clk = ~clk;

    spi_word_master #(.DW(DW), .DIVW(DIVW), .LENW(LENW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .word_len(word_len), .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
        .three_wire(three_wire), .dir_tx(dir_tx), .half_div(half_div),
        .miso(miso), .sio_in(sio_in), .rx_word(rx_word), .done(done),
        .busy(busy), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .sio_oe(sio_oe));

    int n_tests = 0, n_fail = 0;
    bit reported = 0;

    // model peripheral and monitor context
    logic m_cpol, m_cpha, m_lsb, m_3w, m_dtx;
    int m_len = 8, m_d = 1;
    logic [DW-1:0] s_word = '0, cap = '0, rx_at_done = '0;
    bit mon_en = 0;
    int cyc = 0, edge_cnt = 0, ss_low = 0, oe_hi = 0, mosi_hi = 0, mode_err = 0;
    int fall_cyc = 0, rise_cyc = 0, first_edge = 0, last_edge = 0, done_cnt = 0;
    bit done_at_rise = 0;
    logic prev_sclk = 0, prev_ss = 1;
    logic sbit, line;

    function automatic int posn(int k);
        return m_lsb ? k : (m_len - 1 - k);
    endfunction

    always @* begin
        int sidx;
        if (m_cpha) sidx = (edge_cnt == 0) ? 0 : (edge_cnt - 1) / 2;
        else        sidx = edge_cnt / 2;
        if (sidx >= m_len) sidx = m_len - 1;
        sbit = s_word[posn(sidx)];
        line = sio_oe ? mosi : sbit;
        miso   = m_3w ? ~sbit : sbit;
        sio_in = m_3w ? line : ~sbit;
    end

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (!ss_n) ss_low++;
            if (!ss_n && prev_ss) fall_cyc = cyc;
            if (sio_oe) oe_hi++;
            if (!ss_n && mosi) mosi_hi++;
            if (done) begin
                done_cnt++;
                if (ss_n && !prev_ss) done_at_rise = 1;
                rx_at_done = rx_word;
            end
            if (ss_n && !prev_ss) rise_cyc = cyc;
            if (sclk != prev_sclk && !ss_n) begin
                int ec, k;
                bit samp;
                ec = edge_cnt + 1;
                if (ec == 1) first_edge = cyc;
                last_edge = cyc;
                samp = m_cpha ? (ec % 2 == 0) : (ec % 2 == 1);
                if (samp) begin
                    k = m_cpha ? (ec / 2 - 1) : ((ec - 1) / 2);
                    if (sclk !== (m_cpol == m_cpha)) mode_err++;
                    if (k < m_len) cap[posn(k)] = m_3w ? line : mosi;
                end
                edge_cnt = ec;
            end
            prev_sclk = sclk;
            prev_ss = ss_n;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    task automatic xfer(input logic [DW-1:0] tw, input logic [DW-1:0] sw, input int lreq,
                        input bit cp, input bit ch, input bit lf, input bit w3, input bit dt,
                        input int div, input bit poke);
        int L, D, wait_c;
        logic [DW-1:0] mask, exp_rx;
        L = (lreq < 3) ? 3 : (lreq > DW) ? DW : lreq;
        D = (div == 0) ? 1 : div;
        mask = (L == DW) ? '1 : ((DW'(1) << L) - 1'b1);
        @(negedge clk);
        tx_word = tw; word_len = LENW'(lreq); cpol = cp; cpha = ch; lsb_first = lf;
        three_wire = w3; dir_tx = dt; half_div = DIVW'(div);
        m_cpol = cp; m_cpha = ch; m_lsb = lf; m_3w = w3; m_dtx = dt; m_len = L; m_d = D;
        s_word = sw; cap = '0; edge_cnt = 0; ss_low = 0; oe_hi = 0; mosi_hi = 0; mode_err = 0;
        done_cnt = 0; done_at_rise = 0; rx_at_done = '0;
        prev_sclk = sclk; prev_ss = ss_n; mon_en = 1;
        @(negedge clk);
        // R1 idle before the request
        chk(ss_n === 1'b1 && sclk === cp && !sio_oe && !done, "R1", {ss_n, sclk}, {1'b1, cp});
        start = 1;
        @(negedge clk);
        start = 0;
        if (poke) begin
            repeat (2) @(negedge clk);
            // R10 request and new settings while busy
            start = 1; tx_word = ~tw; cpha = ~ch; cpol = ~cp; lsb_first = ~lf;
            word_len = 5'd31; half_div = 8'd7; three_wire = ~w3;
            @(negedge clk);
            start = 0; cpol = cp;
        end
        wait_c = 0;
        while (!done && wait_c < 2000) begin @(negedge clk); wait_c++; end
        chk(wait_c < 2000, "R9 done timeout", wait_c, 0);
        repeat (3) @(negedge clk);
        mon_en = 0;
        exp_rx = (w3 && dt) ? '0 : (sw & mask);
        chk(edge_cnt == 2 * L, "R2 edge count", edge_cnt, 2 * L);
        chk(mode_err == 0, "R3 sample edge level", mode_err, 0);
        if (!(w3 && !dt)) chk((cap & mask) == (tw & mask), "R4 sent word", cap, tw & mask);
        chk(rx_at_done == exp_rx, w3 ? (dt ? "R7 rx" : "R6 rx") : "R5 rx", rx_at_done, exp_rx);
        chk(rx_word == exp_rx, "R9 rx held", rx_word, exp_rx);
        chk(ss_low == D * (2 * L + 2), "R8 select window", ss_low, D * (2 * L + 2));
        chk(first_edge - fall_cyc >= D && rise_cyc - last_edge >= D, "R8 guard",
            first_edge - fall_cyc, D);
        chk(done_cnt == 1 && done_at_rise, "R9 done pulse", done_cnt, 1);
        if (w3 && dt) chk(oe_hi == ss_low, "R7 oe window", oe_hi, ss_low);
        else          chk(oe_hi == 0, w3 ? "R6 oe" : "R5 oe", oe_hi, 0);
        if (w3 && !dt) chk(mosi_hi == 0, "R6 mosi low", mosi_hi, 0);
        chk(ss_n === 1'b1 && sclk === cp, "R1 idle after", sclk, cp);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1c0de);
        m_cpol = 0; m_cpha = 0; m_lsb = 0; m_3w = 0; m_dtx = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ss_n === 1'b1 && sclk === 1'b0 && !done && !sio_oe && rx_word == '0, "R1 reset",
            {ss_n, sclk, done, sio_oe}, 4'b1000);
        rst_n = 1;
        @(negedge clk);
        cpol = 1;
        @(negedge clk);
        chk(sclk === 1'b1, "R1 idle high", sclk, 1);
        cpol = 0;
        // directed corners
        for (int m = 0; m < 4; m++)
            xfer(16'hA5C3, 16'h3C96, 8, m[1], m[0], 0, 0, 0, 2, 0);      // R3 all modes
        xfer(16'h00B1, 16'h004D, 8, 0, 0, 1, 0, 0, 1, 0);                // R4 lsb first
        xfer(16'hFFFF, 16'h0005, 1, 1, 0, 0, 0, 0, 0, 0);                // R2 len clamp low, div 0
        xfer(16'h8001, 16'hC003, 31, 0, 1, 1, 0, 0, 3, 0);               // R2 len clamp high
        xfer(16'h1234, 16'h0ACE, 12, 0, 0, 0, 1, 0, 2, 0);               // R6 shared read
        xfer(16'h0F0F, 16'hFFFF, 16, 1, 1, 0, 1, 1, 1, 0);               // R7 shared write
        xfer(16'h5A5A, 16'h6969, 10, 0, 1, 0, 0, 0, 2, 1);               // R10 poke
        xfer(16'h2222, 16'h1111, 9, 1, 0, 1, 1, 0, 3, 1);                // R10 poke shared
        // random
        for (int i = 0; i < 48; i++) begin
            int unsigned r;
            r = $urandom;
            xfer(DW'($urandom), DW'($urandom), 3 + int'(r % 14), r[4], r[5], r[6], r[7], r[8],
                 int'((r >> 9) % 5), r[12] & r[13]);
        end
        report();
        $finish;
    end
endmodule